// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a free-running 32.768 kHz tick enable into a train of single-cycle event strobes whose spacing is picked by a 4-bit rate code. Nonzero codes select a power-of-two number of ticks between events. Code 0 stops the generator. A separate enable bit gates the whole function.

Codes 1 and 2 are aliases that give the same periods as codes 8 and 9. Each event drives a one-clock set strobe, together with the bit mask that the status register ORs into its flags. Bits 7 and 6 are the two flags involved.

Any change to the rate code or to the enable restarts the tick count from zero. Software therefore always sees a full period before the first event after reprogramming. Register decoding and interrupt delivery live in neighbouring blocks.

Top module: `periodic_rate_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `flag_set_strb` is 0 and `flag_set_mask` is 0x00.
- R2: With `rate_code` equal to 0, no strobe is ever produced, whatever `per_enable` and `tick_en` do.
- R3: With `per_enable` low, no strobe is ever produced, whatever `rate_code` is.
- R4: For a rate code n in the range 3 to 15, with the enable high, a strobe follows every 2^(n-1)-th tick counted from the last restart. For example, code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: Code 1 gives a period of 128 ticks and code 2 gives 256 ticks. These are the same periods as codes 8 and 9.
- R6: Only cycles with `tick_en` high advance the count. A strobe appears only in the cycle right after a clock edge that sampled `tick_en` high.
- R7: A change in `rate_code` or `per_enable` that is sampled at a clock edge clears the count, and the tick in that cycle is not counted. The next strobe comes after a full new period of ticks.
- R8: `flag_set_mask` is 0xC0 (bits 7 and 6 set) in a cycle where `flag_set_strb` is high, and 0x00 otherwise.
- R9: Each strobe is exactly one clock wide, even when `tick_en` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz tick |
| rate_code | input | 4 | Period select; 0 turns the generator off |
| per_enable | input | 1 | Periodic event enable |
| flag_set_strb | output | 1 | One-clock pulse on each expiry |
| flag_set_mask | output | 8 | Status bits to set; 0xC0 during a strobe |

## Verification
A corrupted count or a wrong terminal value shows up as a strobe at the wrong tick index. That error is visible at the latest one period after the fault, which can be up to 16384 ticks for code 15. A missed restart on reprogramming is seen at the first strobe after the change: it arrives early. A stuck or widened strobe shows up in the very next cycle, when the strobe or the mask does not drop back to zero.

// File: rtl/prg_pkg.sv
package prg_pkg;
  // Width of the rate select code
  localparam int CODE_W = 4;
  // Width of the tick counter
  localparam int CNT_W = 15;
  // Width of the status flag set mask
  localparam int FLAG_W = 8;

  // Decoded rate selection
  typedef struct packed {
    logic             active;
    logic [CNT_W-1:0] term;
  } rate_cfg_t;
endpackage

// File: rtl/prg_rate_decode.sv
module prg_rate_decode #(
  parameter int CODE_W    = 4,
  parameter int CNT_W     = 15,
  parameter int ALIAS_MAX = 2,
  parameter int ALIAS_ADD = 7
) (
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output logic              active,
  output logic [CNT_W-1:0]  term
);
  localparam logic [CODE_W-1:0] ALIAS_TOP = CODE_W'(ALIAS_MAX);
  localparam logic [CODE_W:0]   ALIAS_OFS = (CODE_W + 1)'(ALIAS_ADD);
  localparam logic [CODE_W:0]   ONE_E     = (CODE_W + 1)'(1);
  localparam logic [CNT_W-1:0]  ONE_C     = CNT_W'(1);

  logic [CODE_W:0] eff;

  always_comb begin
    if (code <= ALIAS_TOP) eff = {1'b0, code} + ALIAS_OFS;
    else                   eff = {1'b0, code};
  end

  always_comb begin
    active = enable && (code != '0);
    term   = (ONE_C << (eff - ONE_E)) - ONE_C;
  end
endmodule

// File: rtl/prg_change_det.sv
module prg_change_det #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic         restart
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign restart = (prev_q != cur);
endmodule

// File: rtl/prg_tick_counter.sv
module prg_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             active,
  input  logic             restart,
  input  logic [CNT_W-1:0] term,
  output logic             strb
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      strb  <= 1'b0;
    end else begin
      strb <= 1'b0;
      if (!active || restart) begin
        cnt_q <= '0;
      end else if (tick_en) begin
        if (cnt_q == term) begin
          cnt_q <= '0;
          strb  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
  import prg_pkg::*;
#(
  parameter int               P_CODE_W = CODE_W,
  parameter int               P_CNT_W  = CNT_W,
  parameter int               P_FLAG_W = FLAG_W,
  parameter logic [FLAG_W-1:0] SET_MASK = 8'hC0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic [P_CODE_W-1:0] rate_code,
  input  logic                per_enable,
  output logic                flag_set_strb,
  output logic [P_FLAG_W-1:0] flag_set_mask
);
  localparam int WATCH_W = P_CODE_W + 1;

  logic               active;
  logic [P_CNT_W-1:0] term;
  logic               restart;
  logic               strb;

  prg_rate_decode #(.CODE_W(P_CODE_W), .CNT_W(P_CNT_W)) u_dec (
    .code   (rate_code),
    .enable (per_enable),
    .active (active),
    .term   (term)
  );

  prg_change_det #(.W(WATCH_W)) u_chg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur     ({per_enable, rate_code}),
    .restart (restart)
  );

  prg_tick_counter #(.CNT_W(P_CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .active  (active),
    .restart (restart),
    .term    (term),
    .strb    (strb)
  );

  assign flag_set_strb = strb;
  assign flag_set_mask = strb ? P_FLAG_W'(SET_MASK) : '0;
endmodule

// File: rtl/periodic_rate_gen_chk.sv
module periodic_rate_gen_chk #(
  parameter int CW = 4,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic [CW-1:0] rate_code,
  input logic          per_enable,
  input logic          flag_set_strb,
  input logic [FW-1:0] flag_set_mask
);
  // R2
  code_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |=> !flag_set_strb);
  // R3
  enable_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !per_enable |=> !flag_set_strb);
  // R6
  strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_strb |-> $past(tick_en));
  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code != $past(rate_code)) |=> !flag_set_strb);
  // R8
  mask_only_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set_mask != '0) |-> flag_set_strb);
  // R9
  single_cycle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_strb |=> !flag_set_strb);
endmodule

bind periodic_rate_gen periodic_rate_gen_chk #(.CW(P_CODE_W), .FW(P_FLAG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_en       (tick_en),
  .rate_code     (rate_code),
  .per_enable    (per_enable),
  .flag_set_strb (flag_set_strb),
  .flag_set_mask (flag_set_mask)
);

// File: tb/periodic_rate_gen_test.sv
`timescale 1ns/1ps
module periodic_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       per_enable = 1'b0;
  logic       flag_set_strb;
  logic [7:0] flag_set_mask;

  int  vectors = 0;
  int  miscompares = 0;
  int  ticks = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  periodic_rate_gen uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .rate_code     (rate_code),
    .per_enable    (per_enable),
    .flag_set_strb (flag_set_strb),
    .flag_set_mask (flag_set_mask)
  );

  function automatic int period_of(int code);
    int e;
    if (code == 0) return 0;
    e = (code <= 2) ? code + 7 : code;
    return 1 << (e - 1);
  endfunction

  task automatic chk(string req, bit exp_s);
    logic [7:0] exp_m;
    exp_m = exp_s ? 8'hC0 : 8'h00;
    vectors++;
    if (flag_set_strb !== exp_s || flag_set_mask !== exp_m) begin
      miscompares++;
      $display("FAIL %s: strb=%b mask=%h expected strb=%b mask=%h tick=%0d",
               req, flag_set_strb, flag_set_mask, exp_s, exp_m, ticks);
    end
  endtask

  // Apply a new configuration at a negedge; the change cycle carries no tick.
  task automatic cfg(string req, int code, bit en);
    rate_code  = 4'(code);
    per_enable = en;
    tick_en    = 1'b0;
    @(negedge clk);
    chk(req, 1'b0);
    ticks = 0;
  endtask

  // n ticks, each followed by gap idle cycles; per = 0 means no strobe expected.
  task automatic apply(string req, int n, int gap, int per);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      ticks++;
      chk(req, (per != 0) && (ticks % per == 0));
      tick_en = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R6", 1'b0);
      end
    end
    tick_en = 1'b0;
  endtask

  initial begin
    rate_code  = 4'd3;
    per_enable = 1'b1;
    tick_en    = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0);

    // R4 and R5: every code, two full periods, tick on every cycle
    for (int c = 1; c < 16; c++) begin
      cfg("R7", c, 1'b1);
      apply((c <= 2) ? "R5" : "R4", 2 * period_of(c), 0, period_of(c));
    end

    // R9: shortest period with back-to-back ticks
    cfg("R9", 3, 1'b1);
    apply("R9", 40, 0, 4);

    // R6: sparse ticks, only ticks advance the count
    for (int c = 3; c < 7; c++) begin
      cfg("R6", c, 1'b1);
      apply("R6", 3 * period_of(c), 2, period_of(c));
    end

    // R2: code zero never fires
    cfg("R2", 0, 1'b1);
    apply("R2", 20000, 0, 0);

    // R3: enable low never fires
    cfg("R3", 9, 1'b0);
    apply("R3", 600, 0, 0);

    // R7: rate change mid-count restarts
    cfg("R7", 4, 1'b1);
    apply("R7", 5, 0, 8);
    cfg("R7", 5, 1'b1);
    apply("R7", 48, 0, 16);

    // R7: enable toggle restarts
    cfg("R7", 6, 1'b1);
    apply("R7", 20, 0, 32);
    cfg("R3", 6, 1'b0);
    apply("R3", 50, 0, 0);
    cfg("R7", 6, 1'b1);
    apply("R7", 64, 0, 32);

    // R7: alias and true code share a period but the change still restarts
    cfg("R7", 1, 1'b1);
    apply("R7", 100, 0, 128);
    cfg("R7", 8, 1'b1);
    apply("R7", 256, 0, 128);

    // R1: reset mid-count
    cfg("R1", 5, 1'b1);
    apply("R1", 7, 0, 16);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    cfg("R1", 5, 1'b1);
    apply("R8", 32, 1, 16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule